// File: doc/BRIEF.md
# Per-Lane Signed-Amount Vector Shifter

This block shifts every element of a 128-bit data vector by its own distance, and the sign of that distance sets the direction. The distance for each element is the low byte of the matching element of a second vector. That byte is read as a two's-complement number. A positive value moves the element towards its most significant end. A negative value moves it the other way by the magnitude of the byte. The elements can be 8, 16, 32 or 64 bits wide. Each element can be treated as a signed or an unsigned integer.

Two independent options change the result. Rounding adds half of the last discarded weight before a right move. Saturation clamps a left move that would lose significant bits. A sticky flag records that at least one lane clamped since the flag was last cleared. The result and its strobe appear one clock after the operands are presented. The flag updates on the same edge.

Top module: `vshift_unit`

## Requirements
- R1: While reset is held, and on the first edge after it, `out_valid` is 0, `out_data` is all zeros and `sat_flag` is 0.
- R2: `out_valid` equals `in_valid` from the previous clock edge. `out_data` loads the result only on edges where `in_valid` is 1 and otherwise keeps its value.
- R3: `elem_size` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, 2 gives 32 bits and 3 gives 64 bits. Lane k occupies bits [k*W +: W] of both vectors. Its shift amount is bits [k*W +: 8] of `src_b`, read as signed. Any higher bits of a `src_b` lane have no effect.
- R4: A positive amount s shifts the lane left by s when saturation is off. Bits moved past the top are discarded, and s of at least the lane width gives 0.
- R5: A negative amount -n shifts right by n without rounding. Unsigned lanes fill with zeros and signed lanes fill with copies of the sign bit. When n is at least the width, the result is 0, or all ones for a negative signed lane.
- R6: With `round_en` set, a right shift by n returns floor((x + 2^(n-1)) / 2^n), computed without overflow. This includes n at or above the width. Rounding has no effect on left shifts or on an amount of 0.
- R7: With `sat_en` set, a left shift that would change the lane's value is clamped. The clamp is to all ones for an unsigned lane. For a signed lane it is 2^(W-1)-1 when the source is non-negative, and -2^(W-1) when the source is negative.
- R8: An accepted operation (`in_valid`=1, `sat_en`=1) that clamps any lane sets `sat_flag` on the next edge. The flag then stays set until `sat_clr` is asserted.
- R9: `sat_clr` clears `sat_flag` on the next edge, even when a clamping operation is accepted in the same cycle.
- R10: Right shifts never clamp. With `sat_en` at 0, a lossy left shift wraps as in R4 and leaves `sat_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are presented this cycle |
| src_a | input | 128 | Data vector to shift |
| src_b | input | 128 | Vector whose lane low bytes hold the signed shift amounts |
| elem_size | input | 2 | Lane width code (0:8, 1:16, 2:32, 3:64 bits) |
| is_signed | input | 1 | Treat lanes as two's-complement integers |
| round_en | input | 1 | Round right shifts to nearest, ties upward |
| sat_en | input | 1 | Clamp lossy left shifts |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| out_valid | output | 1 | Registered copy of `in_valid` |
| out_data | output | 128 | Registered shifted vector |
| sat_flag | output | 1 | Sticky record of any clamped lane |

## Verification
The bench holds a behavioural model that works on wide signed integers: it multiplies by powers of two, adds the rounding weight, and compares against the lane's range. Every clock it compares the model's result against the outputs. Directed vectors mix several amounts in one vector, including 0, small values, the exact lane width, large positives and -128. This tells the direction decode and the out-of-range handling apart in each lane. Signed and unsigned runs on the same data separate sign fill from zero fill. Rounding runs on odd sources and tie cases separate truncation from rounding. Overflowing left shifts are run with and without saturation, and with the clear input asserted in the same cycle. These separate clamping from wrapping and check the flag's priority. Seeded random operands then cover all four lane widths and every option combination.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

   // Lane width codes; the encoding is log2(width/8).
   typedef enum logic [1:0] {
      ESZ_B8  = 2'd0,
      ESZ_B16 = 2'd1,
      ESZ_B32 = 2'd2,
      ESZ_B64 = 2'd3
   } esz_e;

   localparam int NUM_SIZES = 4;
   localparam int AMT_W     = 8;

   function automatic int lane_width(input int code);
      return 8 << code;
   endfunction

endpackage

// File: rtl/vshift_lane.sv
// One lane: signed-amount shift with optional rounding and clamping.
module vshift_lane #(
   parameter int EW = 8
) (
   input  logic [EW-1:0] x,
   input  logic [7:0]    amt,
   input  logic          sg,
   input  logic          rnd,
   input  logic          sat,
   output logic [EW-1:0] y,
   output logic          sat_hit
);
   localparam int         IW  = $clog2(EW) + 1;
   localparam logic [7:0] EW8 = 8'(EW);

   logic signed [EW:0]   xe;
   logic [7:0]           mag_r;
   logic [6:0]           mag_l;
   logic [IW-1:0]        rs, ri;
   logic                 rbit, lost;
   logic [EW-1:0]        yr, yl, back_u, back_s, clampv;
   logic signed [EW-1:0] yls;

   always_comb begin
      xe     = {sg & x[EW-1], x};
      mag_l  = amt[6:0];
      mag_r  = 8'(~amt + 8'd1);
      // right path: distance clamped to the width, rounding bit from the extended source
      rs     = (mag_r >= EW8) ? IW'(EW) : IW'(mag_r);
      ri     = !amt[7] ? '0 : ((mag_r > EW8) ? IW'(EW) : IW'(mag_r - 8'd1));
      rbit   = rnd & xe[ri];
      yr     = EW'(xe >>> rs) + EW'(rbit);
      // left path with loss detection by shifting back
      yl     = '0;
      yls    = '0;
      back_u = '0;
      back_s = '0;
      lost   = 1'b0;
      if ({1'b0, mag_l} >= EW8) begin
         lost = |x;
      end else begin
         yl     = x << mag_l;
         yls    = yl;
         back_u = yl >> mag_l;
         back_s = yls >>> mag_l;
         lost   = sg ? (back_s != x) : (back_u != x);
      end
      clampv  = sg ? {x[EW-1], {(EW-1){~x[EW-1]}}} : '1;
      sat_hit = ~amt[7] & sat & lost;
      y       = amt[7] ? yr : (sat_hit ? clampv : yl);
   end
endmodule

// File: rtl/vshift_bank.sv
// All lanes of one width across the vector.
module vshift_bank #(
   parameter int VEC_W = 128,
   parameter int EW    = 8
) (
   input  logic [VEC_W-1:0]     a,
   input  logic [VEC_W/EW*8-1:0] amt,
   input  logic                 sg,
   input  logic                 rnd,
   input  logic                 sat,
   output logic [VEC_W-1:0]     y,
   output logic                 hit_any
);
   localparam int NL = VEC_W / EW;

   logic [NL-1:0] hit;

   for (genvar l = 0; l < NL; l++) begin : g_lane
      vshift_lane #(.EW(EW)) i_lane (
         .x      (a[l*EW +: EW]),
         .amt    (amt[l*8 +: 8]),
         .sg     (sg),
         .rnd    (rnd),
         .sat    (sat),
         .y      (y[l*EW +: EW]),
         .sat_hit(hit[l])
      );
   end

   assign hit_any = |hit;
endmodule

// File: rtl/vshift_unit.sv
module vshift_unit
   import vshift_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] src_a,
   input  logic [VEC_W-1:0] src_b,
   input  logic [1:0]       elem_size,
   input  logic             is_signed,
   input  logic             round_en,
   input  logic             sat_en,
   input  logic             sat_clr,
   output logic             out_valid,
   output logic [VEC_W-1:0] out_data,
   output logic             sat_flag
);
   if ((VEC_W % 64) != 0 || VEC_W < 64) begin : g_bad_width
      $error("vshift_unit: VEC_W must be a positive multiple of 64");
   end

   logic [VEC_W-1:0] res_g [NUM_SIZES];
   logic             hit_g [NUM_SIZES];

   for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
      localparam int EW = lane_width(g);
      localparam int NL = VEC_W / EW;
      logic [NL*AMT_W-1:0] amt_g;
      for (genvar l = 0; l < NL; l++) begin : g_amt
         assign amt_g[l*AMT_W +: AMT_W] = src_b[l*EW +: AMT_W];
      end
      vshift_bank #(.VEC_W(VEC_W), .EW(EW)) i_bank (
         .a      (src_a),
         .amt    (amt_g),
         .sg     (is_signed),
         .rnd    (round_en),
         .sat    (sat_en),
         .y      (res_g[g]),
         .hit_any(hit_g[g])
      );
   end

   esz_e             sel;
   logic [VEC_W-1:0] res_sel;
   logic             hit_sel;

   always_comb begin
      sel     = esz_e'(elem_size);
      res_sel = res_g[sel];
      hit_sel = hit_g[sel];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         sat_flag  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) out_data <= res_sel;
         if (sat_clr)                 sat_flag <= 1'b0;
         else if (in_valid & hit_sel) sat_flag <= 1'b1;
      end
   end
endmodule

// File: rtl/vshift_unit_chk.sv
module vshift_unit_chk #(
   parameter int VEC_W = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             sat_en,
   input logic             sat_clr,
   input logic             out_valid,
   input logic [VEC_W-1:0] out_data,
   input logic             sat_flag
);
   assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_data_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data));
   assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_flag && !sat_clr) |=> sat_flag);
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sat_clr |=> !sat_flag);
   assert_no_flag_without_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!sat_en && !sat_clr) |=> $stable(sat_flag));
   assert_flag_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !sat_clr) |=> $stable(sat_flag));
endmodule

bind vshift_unit vshift_unit_chk #(.VEC_W(VEC_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .sat_en   (sat_en),
   .sat_clr  (sat_clr),
   .out_valid(out_valid),
   .out_data (out_data),
   .sat_flag (sat_flag)
);

// File: tb/test_vshift_unit.sv
`timescale 1ns/1ps
module test_vshift_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [127:0] src_a = '0, src_b = '0;
   logic [1:0]   elem_size = '0;
   logic         is_signed = 1'b0, round_en = 1'b0, sat_en = 1'b0, sat_clr = 1'b0;
   logic         out_valid, sat_flag;
   logic [127:0] out_data;

   int n_vec = 0, n_bad = 0;
   bit done = 0;

   logic [127:0] exp_data = '0;
   logic         exp_valid = 1'b0, exp_flag = 1'b0;

   always #5 clk = ~clk;

   vshift_unit i_vshift_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
      .elem_size(elem_size), .is_signed(is_signed), .round_en(round_en),
      .sat_en(sat_en), .sat_clr(sat_clr), .out_valid(out_valid),
      .out_data(out_data), .sat_flag(sat_flag)
   );

   localparam logic signed [255:0] ZERO = 256'sd0;
   localparam logic signed [255:0] ONE  = 256'sd1;

   // Behavioural lane arithmetic on wide signed integers.
   function automatic logic [127:0] ref_shift(input logic [127:0] a, input logic [127:0] b,
                                              input int sz, input bit sg, input bit rnd,
                                              input bit sat, output bit hit);
      int ew = 8 << sz;
      int nl = 128 / ew;
      logic [127:0] r = '0;
      logic [63:0]  raw, mask;
      logic signed [255:0] xv, full, maxv, minv;
      int amt;
      hit = 1'b0;
      mask = (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
      for (int l = 0; l < nl; l++) begin
         raw = 64'(a >> (l*ew)) & mask;
         xv  = {192'd0, raw};
         if (sg && raw[ew-1]) xv = xv - (ONE <<< ew);
         amt = int'($signed(b[l*ew +: 8]));
         if (amt >= 0) begin
            full = xv <<< amt;
            maxv = sg ? (ONE <<< (ew-1)) - ONE : (ONE <<< ew) - ONE;
            minv = sg ? -(ONE <<< (ew-1)) : ZERO;
            if (sat && full > maxv) begin full = maxv; hit = 1'b1; end
            else if (sat && full < minv) begin full = minv; hit = 1'b1; end
         end else begin
            full = (xv + (rnd ? (ONE <<< (-amt-1)) : ZERO)) >>> (-amt);
         end
         r = r | ((128'(full[63:0]) & 128'(mask)) << (l*ew));
      end
      return r;
   endfunction

   task automatic compare(input string tag);
      n_vec++;
      if (out_valid !== exp_valid || out_data !== exp_data || sat_flag !== exp_flag) begin
         n_bad++;
         $display("FAIL %s: valid=%b/%b data=%h/%h flag=%b/%b (actual/expected)",
                  tag, out_valid, exp_valid, out_data, exp_data, sat_flag, exp_flag);
      end
   endtask

   // Drive at the falling edge, update the model after the rising edge, check at the next falling edge.
   task automatic step(input bit v, input logic [127:0] a, input logic [127:0] b,
                       input int sz, input bit sg, input bit rnd, input bit sat,
                       input bit clr, input string tag);
      bit hit;
      logic [127:0] r;
      in_valid = v; src_a = a; src_b = b; elem_size = 2'(sz);
      is_signed = sg; round_en = rnd; sat_en = sat; sat_clr = clr;
      @(posedge clk);
      r = ref_shift(a, b, sz, sg, rnd, sat, hit);
      exp_valid = v;
      if (v) exp_data = r;
      if (clr) exp_flag = 1'b0;
      else if (v && hit) exp_flag = 1'b1;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R1 during reset");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1 after reset");

      // R3/R4: byte lanes, mixed left amounts including the width and beyond
      step(1, {16{8'hA5}}, 128'h64_08_07_03_01_00_02_05_06_04_09_7F_0A_10_20_00, 0, 0, 0, 0, 0, "R4 u8 left wrap");
      step(1, {16{8'hA5}}, 128'h64_08_07_03_01_00_02_05_06_04_09_7F_0A_10_20_00, 0, 1, 0, 0, 0, "R4 s8 left wrap");
      // R3/R5: halfword lanes, negative amounts, garbage in upper amount byte
      step(1, 128'h8001_7FFF_F00F_0123_FFFF_8000_4321_C3C3, 128'hABF0_1280_77FF_00F8_3CF1_5AF0_99FC_EEFF, 1, 1, 0, 0, 0, "R5 s16 right");
      step(1, 128'h8001_7FFF_F00F_0123_FFFF_8000_4321_C3C3, 128'hABF0_1280_77FF_00F8_3CF1_5AF0_99FC_EEFF, 1, 0, 0, 0, 0, "R5 u16 right");
      // R6: rounding on word lanes, ties and far distances, plus a left shift
      step(1, 128'h0000_0003_8000_0001_FFFF_FFFF_7FFF_FFFF, 128'h0000_00FF_0000_00E1_0000_00E0_0000_00DF, 2, 0, 1, 0, 0, "R6 u32 round");
      step(1, 128'h0000_0003_8000_0001_FFFF_FFFF_7FFF_FFFF, 128'h0000_00FF_0000_00E1_0000_00E0_0000_00DF, 2, 1, 1, 0, 0, "R6 s32 round");
      step(1, 128'hFFFF_FFFD_8000_0001_0000_0005_7FFF_FFFF, 128'h0000_00FF_0000_0003_0000_0000_0000_0080, 2, 1, 1, 0, 0, "R6 s32 round mixed");
      // R7/R8: doubleword signed clamp both directions
      step(1, 128'h4000_0000_0000_0000_C000_0000_0000_0001, 128'h0000_0000_0000_0001_0000_0000_0000_0002, 3, 1, 0, 1, 0, "R7 s64 clamp R8 set");
      step(0, '0, '0, 0, 0, 0, 0, 0, "R2 hold R8 sticky");
      step(0, '1, '1, 3, 1, 1, 1, 0, "R2 hold idle R8 sticky");
      step(1, {16{8'h81}}, {16{8'h01}}, 0, 0, 0, 1, 0, "R7 u8 clamp");
      step(0, '0, '0, 0, 0, 0, 0, 1, "R8 clear");
      step(1, {16{8'h81}}, {16{8'h01}}, 0, 1, 0, 1, 1, "R9 clear beats event");
      step(0, '0, '0, 0, 0, 0, 0, 0, "R9 after clear");
      // R10: lossy left without saturation, and right shifts with saturation on
      step(1, 128'h4000_0000_0000_0000_C000_0000_0000_0001, 128'h0000_0000_0000_0005_0000_0000_0000_0040, 3, 1, 0, 0, 0, "R10 wrap no flag");
      step(1, {8{16'h8000}}, {8{16'h00FF}}, 1, 1, 1, 1, 0, "R10 right no clamp");
      step(1, {16{8'h7F}}, {16{8'h00}}, 0, 1, 1, 1, 0, "R6 zero amount");

      for (int i = 0; i < 400; i++) begin
         logic [127:0] ra, rb;
         ra = {$urandom, $urandom, $urandom, $urandom};
         rb = {$urandom, $urandom, $urandom, $urandom};
         if (i % 3 == 0) rb = rb & {16{8'h8F}};
         step($urandom_range(0, 3) != 0, ra, rb, $urandom_range(0, 3), 1'($urandom),
              1'($urandom), 1'($urandom), ($urandom_range(0, 9) == 0), "R3 random");
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule